// File: doc/BRIEF.md
# Cascaded Multi-Domain Reset Sequencer

This block takes a single asynchronous, active-low root reset and produces one active-low reset for each of `N_DOMAINS` clock domains. The domain clocks are free-running and need no frequency or phase relationship to each other. Entry into reset is immediate in every domain and needs no clock edge. Exit from reset runs as a relay. Domain 0 leaves reset first. Each later domain waits until the domain before it has left reset, then leaves reset on its own clock. The domains therefore come up one after another in index order, never together.

Each domain has one bridge stage. The stage is a small state machine in thermometer code, so only one flop changes on each step. Its states are HELD (000), CAUGHT (001), SETTLED (011) and LIVE (111).

- The upstream reset going active forces HELD asynchronously.
- While the upstream reset is inactive, each rising edge of the domain clock steps the machine HELD→CAUGHT, then CAUGHT→SETTLED, then SETTLED→LIVE. LIVE then holds (LIVE→LIVE).
- Any encoding outside these four states returns to HELD.
- The low two bits are the two-flop synchronizer. The top bit is the extra staging flop, and the domain's reset output is taken straight from it.
- The output of domain k is the upstream reset of domain k+1.

Top module: `rst_cascade_seq`

## Requirements
- R1: While `rst_root_n` is 0, every bit of `rst_dom_n` is 0. When `rst_root_n` falls, all bits go to 0 in the same time step, with no clock edge needed.
- R2: `rst_dom_n[0]` becomes 1 on the third rising edge of `clk_dom[0]` after `rst_root_n` rises, and not earlier.
- R3: For k ≥ 1, `rst_dom_n[k]` becomes 1 on the third rising edge of `clk_dom[k]` after `rst_dom_n[k-1]` rises, and not earlier.
- R4: Releases occur in strictly increasing domain order. Bit k never rises while bit k-1 is 0, and never in the same instant as bit k-1. The bits that are 1 always form a contiguous run starting at bit 0.
- R5: If `rst_root_n` falls partway through a release sequence, all outputs return to 0 at once. After the next rise of `rst_root_n`, the sequence restarts from domain 0 with full three-edge latencies.
- R6: A low pulse on `rst_root_n` shorter than any clock period still drives all outputs to 0. The full release sequence then repeats.
- R7: Once released, `rst_dom_n[k]` stays 1 for as long as `rst_root_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dom | input | N_DOMAINS | One free-running clock per domain; bit k clocks bridge k |
| rst_root_n | input | 1 | Asynchronous root reset, active low |
| rst_dom_n | output | N_DOMAINS | Per-domain reset, active low; bit k is synchronous to `clk_dom[k]` on release |

## Verification
The checker assumes the following about the inputs:
- Every domain clock keeps toggling.
- A change of `rst_root_n` never lands on the same instant as a rising edge of `clk_dom[0]`, so that each edge sees a settled upstream level.
- No two domain clocks share an edge instant, so an upstream release is never simultaneous with a downstream edge.

The bench stays within these limits. All clock edges sit on distinct 10 ps slots inside each 100 ps step, and the root reset is driven only on the 50 ps slot. Short reset pulses are still allowed, because the upstream level is only ever sampled at clock edges.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

    // two synchronizer flops plus one staging flop
    localparam int SYNC_FLOPS  = 2;
    localparam int BRIDGE_W    = SYNC_FLOPS + 1;
    localparam int STAGE_BIT   = BRIDGE_W - 1;

    // thermometer code: exactly one flop changes per step
    typedef enum logic [BRIDGE_W-1:0] {
        BR_HELD    = 3'b000,
        BR_CAUGHT  = 3'b001,
        BR_SETTLED = 3'b011,
        BR_LIVE    = 3'b111
    } bridge_state_e;

endpackage

// File: rtl/rst_bridge_stage.sv
`timescale 1ns/1ps
module rst_bridge_stage
    import rst_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_up_n,
    output logic rst_out_n
);

    bridge_state_e state_q;
    bridge_state_e state_d;

    // state register: asynchronous entry into HELD
    always_ff @(posedge clk or negedge rst_up_n) begin
        if (!rst_up_n) begin
            state_q <= BR_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    // shift a constant 1 through the thermometer
    always_comb begin
        state_d = BR_HELD;
        unique case (state_q)
            BR_HELD:    state_d = BR_CAUGHT;
            BR_CAUGHT:  state_d = BR_SETTLED;
            BR_SETTLED: state_d = BR_LIVE;
            BR_LIVE:    state_d = BR_LIVE;
            default:    state_d = BR_HELD;
        endcase
    end

    // output taken directly from the staging flop, no gate in between
    always_comb begin
        rst_out_n = state_q[STAGE_BIT];
    end

endmodule

// File: rtl/rst_cascade_seq.sv
`timescale 1ns/1ps
module rst_cascade_seq #(
    parameter int N_DOMAINS = 4
) (
    input  logic [N_DOMAINS-1:0] clk_dom,
    input  logic                 rst_root_n,
    output logic [N_DOMAINS-1:0] rst_dom_n
);

    localparam int CHAIN_W = N_DOMAINS + 1;

    // chain_n[k] is the upstream reset of bridge k
    logic [CHAIN_W-1:0] chain_n;

    assign chain_n[0] = rst_root_n;

    generate
        for (genvar g = 0; g < N_DOMAINS; g++) begin : g_bridge
            rst_bridge_stage u_bridge (
                .clk       (clk_dom[g]),
                .rst_up_n  (chain_n[g]),
                .rst_out_n (chain_n[g+1])
            );
        end
    endgenerate

    assign rst_dom_n = chain_n[CHAIN_W-1:1];

endmodule

// File: rtl/rst_cascade_seq_chk.sv
`timescale 1ns/1ps
module rst_cascade_seq_chk #(
    parameter int N_DOMAINS = 4
) (
    input logic [N_DOMAINS-1:0] clk_dom,
    input logic                 rst_root_n,
    input logic [N_DOMAINS-1:0] rst_dom_n
);

    logic [N_DOMAINS-1:0] up_n;

    generate
        for (genvar g = 0; g < N_DOMAINS; g++) begin : g_dom
            if (g == 0) begin : g_first
                assign up_n[g] = rst_root_n;
            end else begin : g_rest
                assign up_n[g] = rst_dom_n[g-1];
            end

            // R1: no domain is seen released while the root is active
            p_held_in_reset_r1: assert property (
                @(posedge clk_dom[g]) !rst_root_n |-> !rst_dom_n[g]
            ) else $error("p_held_in_reset_r1 domain %0d", g);

            // R2/R3: release only after three local edges saw upstream inactive
            p_three_edge_release_r3: assert property (
                @(posedge clk_dom[g]) disable iff (!rst_root_n)
                $rose(rst_dom_n[g]) |->
                    ($past(up_n[g], 1) && $past(up_n[g], 2) && $past(up_n[g], 3))
            ) else $error("p_three_edge_release_r3 domain %0d", g);

            if (g > 0) begin : g_order
                // R4: a released domain implies its predecessor is released
                p_after_upstream_r4: assert property (
                    @(posedge clk_dom[g]) disable iff (!rst_root_n)
                    rst_dom_n[g] |-> rst_dom_n[g-1]
                ) else $error("p_after_upstream_r4 domain %0d", g);
            end
        end
    endgenerate

    // R4: released bits form a run of ones from bit 0
    p_release_prefix_r4: assert property (
        @(posedge clk_dom[0]) disable iff (!rst_root_n)
        (rst_dom_n & (rst_dom_n + N_DOMAINS'(1))) == '0
    ) else $error("p_release_prefix_r4");

endmodule

bind rst_cascade_seq rst_cascade_seq_chk #(.N_DOMAINS(N_DOMAINS)) u_chk (
    .clk_dom    (clk_dom),
    .rst_root_n (rst_root_n),
    .rst_dom_n  (rst_dom_n)
);

// File: tb/tb_rst_cascade_seq.sv
`timescale 1ns/1ps
module tb_rst_cascade_seq;

    localparam int N = 4;

    typedef struct packed {
        logic [15:0]  run_ns;
        logic [N-1:0] exp_n;
        logic [N-1:0] care;
    } scen_t;

    // release time, expected outputs at end of it, bits that are predictable
    localparam scen_t SCEN [6] = '{
        '{16'd200, 4'hF, 4'hF},
        '{16'd7,   4'h0, 4'hF},
        '{16'd25,  4'h0, 4'h0},
        '{16'd50,  4'h0, 4'h0},
        '{16'd8,   4'h0, 4'hF},
        '{16'd300, 4'hF, 4'hF}
    };

    logic [N-1:0] clk_dom;
    logic         rst_root_n;
    logic [N-1:0] rst_dom_n;

    int  total = 0;
    int  bad   = 0;
    real rel_t [N];

    rst_cascade_seq #(.N_DOMAINS(N)) dut (
        .clk_dom    (clk_dom),
        .rst_root_n (rst_root_n),
        .rst_dom_n  (rst_dom_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic real half_of(input int k);
        case (k)
            0:       return 2.0;   // 250 MHz
            1:       return 2.6;
            2:       return 3.3;
            default: return 1.7;
        endcase
    endfunction

    // clocks: edges of domain k land on the k*10 ps slot of each 100 ps step
    // per-domain reference model of the three-edge release
    generate
        for (genvar g = 0; g < N; g++) begin : g_clk
            logic c;
            logic up_w;
            int   cnt;
            assign clk_dom[g] = c;
            if (g == 0) begin : g_u0
                assign up_w = rst_root_n;
            end else begin : g_uk
                assign up_w = rst_dom_n[g-1];
            end
            initial begin
                c = 1'b0;
                #(1.0 + 0.01 * g);
                forever #(half_of(g)) c = ~c;
            end
            initial cnt = 0;
            always @(posedge c or negedge up_w) begin
                if (!up_w) cnt = 0;
                else if (cnt < 3) cnt = cnt + 1;
                #0.005;
                if (g == 0)
                    chk(rst_dom_n[g] == (cnt >= 3), "R2 domain0 three-edge release", 32'(rst_dom_n[g]), 32'(cnt >= 3));
                else
                    chk(rst_dom_n[g] == (cnt >= 3), "R3 domain-k three-edge release", 32'(rst_dom_n[g]), 32'(cnt >= 3));
            end
        end
    endgenerate

    // ordering monitor: each rising bit needs root inactive and predecessor already released
    logic [N-1:0] prev_n = '0;
    always @(rst_dom_n) begin
        for (int k = 0; k < N; k++) begin
            if (rst_dom_n[k] === 1'b1 && prev_n[k] !== 1'b1) begin
                rel_t[k] = $realtime;
                chk(rst_root_n === 1'b1, "R1 release while root active", 32'(rst_root_n), 32'd1);
                if (k > 0)
                    chk(prev_n[k-1] === 1'b1, "R4 release before predecessor", 32'(prev_n), 32'(k));
            end
        end
        prev_n = rst_dom_n;
    end

    task automatic check_order();
        for (int k = 1; k < N; k++)
            chk(rel_t[k] > rel_t[k-1], "R4 release times increasing", 32'($rtoi(rel_t[k] * 100.0)), 32'($rtoi(rel_t[k-1] * 100.0)));
    endtask

    initial begin
        #50000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_root_n = 1'b0;
        #100.05;
        // reset state after many clock edges
        chk(rst_dom_n == '0, "R1 reset state", 32'(rst_dom_n), 32'd0);

        // table of release windows
        for (int i = 0; i < 6; i++) begin
            rst_root_n = 1'b1;
            #(int'(SCEN[i].run_ns));
            chk((rst_dom_n & SCEN[i].care) == (SCEN[i].exp_n & SCEN[i].care),
                "R5 outputs at end of release window", 32'(rst_dom_n), 32'(SCEN[i].exp_n));
            if (SCEN[i].care == '1 && SCEN[i].exp_n == '1) check_order();
            rst_root_n = 1'b0;
            #1;
            chk(rst_dom_n == '0, "R1 asynchronous entry", 32'(rst_dom_n), 32'd0);
            #20;
        end

        // abort mid-sequence, then restart from domain 0
        rst_root_n = 1'b1;
        #25;
        rst_root_n = 1'b0;
        #0.001;
        chk(rst_dom_n == '0, "R5 abort drops all outputs", 32'(rst_dom_n), 32'd0);
        #0.999;
        rst_root_n = 1'b1;
        #7;
        chk(rst_dom_n == '0, "R5 restart begins at domain 0", 32'(rst_dom_n), 32'd0);
        #200;
        chk(rst_dom_n == '1, "R5 restart completes", 32'(rst_dom_n), 32'hF);
        check_order();

        // stays released
        for (int j = 0; j < 20; j++) begin
            #10;
            chk(rst_dom_n == '1, "R7 stays released", 32'(rst_dom_n), 32'hF);
        end

        // pulse shorter than any clock period
        rst_root_n = 1'b0;
        #0.5;
        chk(rst_dom_n == '0, "R6 short pulse resets", 32'(rst_dom_n), 32'd0);
        #0.5;
        rst_root_n = 1'b1;
        #0.001;
        chk(rst_dom_n == '0, "R6 no release without edges", 32'(rst_dom_n), 32'd0);
        #199.999;
        chk(rst_dom_n == '1, "R6 sequence repeats", 32'(rst_dom_n), 32'hF);
        check_order();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule